// File: doc/BRIEF.md
# Two-Axis Complex Gain Predistorter

This block corrects static amplifier nonlinearity at baseband, one sample per clock. Each incoming complex sample comes with two operating-point values: the envelope magnitude of that sample and a code for the instantaneous supply voltage. Together they select a point on a grid of stored complex gains. The block blends the four grid cells around that point by bilinear interpolation. It then multiplies the sample by the blended gain, so the output is both scaled in amplitude and rotated in phase.

The correction has no memory. Each output depends only on its own sample and its own two index values. A write port loads or replaces individual grid cells while traffic runs. This lets a controller install new coefficients after the supply shaping or the bias point changes. Results come out after a fixed pipeline delay, with a valid flag that follows the input valid flag.

Top module: `dpd_twoaxis_predist`

## Requirements
- R1: With default parameters, the grid index on the magnitude axis is `in_mag[11:6]` and the magnitude fraction is `in_mag[5:0]`. On the supply axis the index is `in_sup[7:4]` and the fraction is `in_sup[3:0]`. The table has 64 × 16 cells.
- R2: When the lower index on an axis is at its last grid point (all ones), the upper neighbour on that axis is the same cell.
- R3: Each part of the gain is computed from the corners g00 (lower mag, lower sup), g10 (upper mag), g01 (upper sup) and g11 (both upper). First a0 = g00·(64−fm) + g10·fm and a1 = g01·(64−fm) + g11·fm. Then G = floor((a0·(16−fs) + a1·fs + 512) / 1024).
- R4: Samples are signed Q1.15 and gains are signed Q2.14. The output is out_i = rs(x_i·G_i − x_q·G_q) and out_q = rs(x_i·G_q + x_q·G_i). Here rs(p) = floor((p + 8192) / 16384), saturated to the range [−32768, 32767].
- R5: `out_valid` is exactly `in_valid` delayed by 4 cycles (3 + OUT_STAGES). No output valid appears for a cycle in which `in_valid` was low.
- R6: The block is memoryless. An output depends only on its own sample, magnitude, supply value and the current table, and never on earlier samples.
- R7: A write with `wr_en` high stores `wr_data` into the cell at (`wr_mag_idx`, `wr_sup_idx`). The gain's I part is `wr_data[31:16]` and its Q part is `wr_data[15:0]`. A sample presented in the same cycle as the write still reads the old contents. Samples presented in any later cycle read the new contents.
- R8: Synchronous active-high `rst` clears every pipeline valid bit, so `out_valid` is low after reset. Reset does not alter the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_i | input | 16 | Sample in-phase part, Q1.15 |
| in_q | input | 16 | Sample quadrature part, Q1.15 |
| in_mag | input | MAG_W (12) | Envelope magnitude of the sample |
| in_sup | input | SUP_W (8) | Supply-voltage code |
| wr_en | input | 1 | Table write strobe |
| wr_mag_idx | input | MAG_IDX_W (6) | Magnitude grid index of the written cell |
| wr_sup_idx | input | SUP_IDX_W (4) | Supply grid index of the written cell |
| wr_data | input | 32 | Gain: [31:16] I, [15:0] Q, Q2.14 |
| out_valid | output | 1 | Output qualifier |
| out_i | output | 16 | Corrected in-phase part, Q1.15 |
| out_q | output | 16 | Corrected quadrature part, Q1.15 |

## Verification
Each sample, and the table image current in its cycle, produces a result that is due on the ports exactly four clocks after the edge that captured it. That covers one stage for the table read, two for interpolation and one for the complex product. The reference model pushes one expected entry per driven cycle into a queue and pops the entry from four cycles earlier at every falling edge. Any shift in latency or valid alignment therefore shows up as a miscompare. A reset marks every queued entry as invalid, because every stage is cleared at that edge. Table writes are applied to the model only after the same cycle's sample has been evaluated, which matches the one-cycle write visibility.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    localparam int SMP_W     = 16;
    localparam int GAIN_FRAC = 14;
    localparam int PROD_W    = 34;

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } cplx_t;

    localparam logic signed [PROD_W-1:0] RND_HALF = 34'sd8192;
    localparam logic signed [PROD_W-1:0] LIM_HI   = 34'sd32767;
    localparam logic signed [PROD_W-1:0] LIM_LO   = -34'sd32768;

    // Round a Q3.29-scaled product to Q1.15 and clip to 16 bits.
    function automatic logic signed [SMP_W-1:0] round_sat(input logic signed [PROD_W-1:0] p);
        logic signed [PROD_W-1:0] r;
        r = (p + RND_HALF) >>> GAIN_FRAC;
        if (r > LIM_HI)      return 16'sh7FFF;
        else if (r < LIM_LO) return 16'sh8000;
        else                 return r[SMP_W-1:0];
    endfunction

endpackage

// File: rtl/dpd_gain_table.sv
module dpd_gain_table
    import dpd_pkg::*;
#(
    parameter int MAG_W     = 12,
    parameter int SUP_W     = 8,
    parameter int MAG_IDX_W = 6,
    parameter int SUP_IDX_W = 4,
    localparam int FM_W     = MAG_W - MAG_IDX_W,
    localparam int FS_W     = SUP_W - SUP_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  cplx_t                in_smp,
    input  logic [MAG_W-1:0]     in_mag,
    input  logic [SUP_W-1:0]     in_sup,
    input  logic                 wr_en,
    input  logic [MAG_IDX_W-1:0] wr_mag_idx,
    input  logic [SUP_IDX_W-1:0] wr_sup_idx,
    input  logic [31:0]          wr_data,
    output cplx_t [3:0]          crn,
    output logic [FM_W-1:0]      fm,
    output logic [FS_W-1:0]      fs,
    output cplx_t                smp,
    output logic                 vld
);

    localparam int CELLS  = (1 << MAG_IDX_W) * (1 << SUP_IDX_W);
    localparam int ADDR_W = MAG_IDX_W + SUP_IDX_W;

    logic [31:0] mem [CELLS];

    logic [MAG_IDX_W-1:0] m_lo, m_hi;
    logic [SUP_IDX_W-1:0] s_lo, s_hi;

    always_comb begin
        m_lo = in_mag[MAG_W-1 -: MAG_IDX_W];
        s_lo = in_sup[SUP_W-1 -: SUP_IDX_W];
        m_hi = (m_lo == '1) ? m_lo : m_lo + 1'b1;
        s_hi = (s_lo == '1) ? s_lo : s_lo + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_sup_idx, wr_mag_idx}] <= wr_data;
    end

    // Corner c: bit 0 picks the upper magnitude point, bit 1 the upper supply point.
    for (genvar c = 0; c < 4; c++) begin : g_corner
        logic [ADDR_W-1:0] addr;
        always_comb addr = {((c & 2) != 0) ? s_hi : s_lo, ((c & 1) != 0) ? m_hi : m_lo};
        always_ff @(posedge clk) crn[c] <= cplx_t'(mem[addr]);
    end

    always_ff @(posedge clk) begin
        fm  <= in_mag[FM_W-1:0];
        fs  <= in_sup[FS_W-1:0];
        smp <= in_smp;
        if (rst) vld <= 1'b0;
        else     vld <= in_valid;
    end

    // R2
    clamp_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_mag[MAG_W-1 -: MAG_IDX_W] == '1) |=> (crn[1] == crn[0]));

    // R2
    clamp_sup_chk: assert property (@(posedge clk) disable iff (rst)
        (in_sup[SUP_W-1 -: SUP_IDX_W] == '1) |=> (crn[2] == crn[0]));

endmodule

// File: rtl/dpd_bilerp.sv
module dpd_bilerp
    import dpd_pkg::*;
#(
    parameter int FM_W = 6,
    parameter int FS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            v1,
    input  cplx_t [3:0]     crn,
    input  logic [FM_W-1:0] fm,
    input  logic [FS_W-1:0] fs,
    input  cplx_t           smp1,
    output logic            v3,
    output cplx_t           gain,
    output cplx_t           smp3
);

    localparam int MW    = SMP_W + FM_W + 2;
    localparam int SW    = MW + FS_W + 2;
    localparam int SH    = FM_W + FS_W;
    localparam int ONE_M = 1 << FM_W;
    localparam int ONE_S = 1 << FS_W;

    function automatic logic signed [MW-1:0] lerp_m(input logic signed [SMP_W-1:0] lo,
                                                    input logic signed [SMP_W-1:0] hi,
                                                    input logic [FM_W-1:0] f);
        logic signed [MW-1:0] wh, wl;
        wh = MW'(f);
        wl = MW'(ONE_M) - wh;
        return MW'(lo) * wl + MW'(hi) * wh;
    endfunction

    function automatic logic signed [SMP_W-1:0] lerp_s(input logic signed [MW-1:0] lo,
                                                       input logic signed [MW-1:0] hi,
                                                       input logic [FS_W-1:0] f);
        logic signed [SW-1:0] wh, wl, acc;
        wh  = SW'(f);
        wl  = SW'(ONE_S) - wh;
        acc = SW'(lo) * wl + SW'(hi) * wh;
        acc = (acc + SW'(1 << (SH - 1))) >>> SH;
        return acc[SMP_W-1:0];
    endfunction

    // Stage 2: blend along the magnitude axis
    logic signed [MW-1:0] a0_re, a0_im, a1_re, a1_im;
    logic [FS_W-1:0]      fs2;
    cplx_t                smp2;
    logic                 v2;

    always_ff @(posedge clk) begin
        a0_re <= lerp_m(crn[0].re, crn[1].re, fm);
        a0_im <= lerp_m(crn[0].im, crn[1].im, fm);
        a1_re <= lerp_m(crn[2].re, crn[3].re, fm);
        a1_im <= lerp_m(crn[2].im, crn[3].im, fm);
        fs2   <= fs;
        smp2  <= smp1;
        if (rst) v2 <= 1'b0;
        else     v2 <= v1;
    end

    // Stage 3: blend along the supply axis and round
    always_ff @(posedge clk) begin
        gain.re <= lerp_s(a0_re, a1_re, fs2);
        gain.im <= lerp_s(a0_im, a1_im, fs2);
        smp3    <= smp2;
        if (rst) v3 <= 1'b0;
        else     v3 <= v2;
    end

    // R3
    flat_cell_chk: assert property (@(posedge clk) disable iff (rst)
        (crn[0] == crn[1] && crn[0] == crn[2] && crn[0] == crn[3])
        |=> ##1 (gain == $past(crn[0], 2)));

endmodule

// File: rtl/dpd_cmul.sv
module dpd_cmul
    import dpd_pkg::*;
#(
    parameter int OUT_STAGES = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  v3,
    input  cplx_t gain,
    input  cplx_t smp3,
    output logic  out_valid,
    output cplx_t out_smp
);

    logic signed [PROD_W-1:0] pr_re, pr_im;

    always_comb begin
        pr_re = PROD_W'(smp3.re) * PROD_W'(gain.re) - PROD_W'(smp3.im) * PROD_W'(gain.im);
        pr_im = PROD_W'(smp3.re) * PROD_W'(gain.im) + PROD_W'(smp3.im) * PROD_W'(gain.re);
    end

    cplx_t                 pipe [OUT_STAGES];
    logic [OUT_STAGES-1:0] pv;

    always_ff @(posedge clk) begin
        pipe[0].re <= round_sat(pr_re);
        pipe[0].im <= round_sat(pr_im);
        for (int k = 1; k < OUT_STAGES; k++) pipe[k] <= pipe[k-1];
    end

    if (OUT_STAGES > 1) begin : g_multi
        always_ff @(posedge clk) begin
            if (rst) pv <= '0;
            else     pv <= {pv[OUT_STAGES-2:0], v3};
        end
    end else begin : g_single
        always_ff @(posedge clk) begin
            if (rst) pv <= '0;
            else     pv <= v3;
        end
    end

    assign out_valid = pv[OUT_STAGES-1];
    assign out_smp   = pipe[OUT_STAGES-1];

    // R4
    unity_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (gain.re == 16'sd16384 && gain.im == 16'sd0) |=> (pipe[0] == $past(smp3)));

    // R4
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        (gain.re == 16'sh7FFF && gain.im == 16'sd0 && smp3.re == 16'sh7FFF)
        |=> (pipe[0].re == 16'sh7FFF));

endmodule

// File: rtl/dpd_twoaxis_predist.sv
module dpd_twoaxis_predist
    import dpd_pkg::*;
#(
    parameter int MAG_W      = 12,
    parameter int SUP_W      = 8,
    parameter int MAG_IDX_W  = 6,
    parameter int SUP_IDX_W  = 4,
    parameter int OUT_STAGES = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [15:0]          in_i,
    input  logic [15:0]          in_q,
    input  logic [MAG_W-1:0]     in_mag,
    input  logic [SUP_W-1:0]     in_sup,
    input  logic                 wr_en,
    input  logic [MAG_IDX_W-1:0] wr_mag_idx,
    input  logic [SUP_IDX_W-1:0] wr_sup_idx,
    input  logic [31:0]          wr_data,
    output logic                 out_valid,
    output logic [15:0]          out_i,
    output logic [15:0]          out_q
);

    localparam int FM_W    = MAG_W - MAG_IDX_W;
    localparam int FS_W    = SUP_W - SUP_IDX_W;
    localparam int LATENCY = 3 + OUT_STAGES;

    cplx_t            smp0, smp1, smp3, gain, res;
    cplx_t [3:0]      crn;
    logic [FM_W-1:0]  fm;
    logic [FS_W-1:0]  fs;
    logic             v1, v3;

    assign smp0.re = in_i;
    assign smp0.im = in_q;

    dpd_gain_table #(
        .MAG_W(MAG_W), .SUP_W(SUP_W), .MAG_IDX_W(MAG_IDX_W), .SUP_IDX_W(SUP_IDX_W)
    ) u_tab (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_smp(smp0),
        .in_mag(in_mag), .in_sup(in_sup),
        .wr_en(wr_en), .wr_mag_idx(wr_mag_idx), .wr_sup_idx(wr_sup_idx), .wr_data(wr_data),
        .crn(crn), .fm(fm), .fs(fs), .smp(smp1), .vld(v1)
    );

    dpd_bilerp #(.FM_W(FM_W), .FS_W(FS_W)) u_lerp (
        .clk(clk), .rst(rst), .v1(v1), .crn(crn), .fm(fm), .fs(fs), .smp1(smp1),
        .v3(v3), .gain(gain), .smp3(smp3)
    );

    dpd_cmul #(.OUT_STAGES(OUT_STAGES)) u_mul (
        .clk(clk), .rst(rst), .v3(v3), .gain(gain), .smp3(smp3),
        .out_valid(out_valid), .out_smp(res)
    );

    assign out_i = res.re;
    assign out_q = res.im;

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    // R5
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !rst) |=> !v1);

endmodule

// File: tb/sim_dpd_twoaxis_predist.sv
module sim_dpd_twoaxis_predist;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int MPTS       = 64;
    localparam int SPTS       = 16;

    typedef struct {
        bit    v;
        int    i;
        int    q;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0, in_q = '0;
    logic [11:0] in_mag = '0;
    logic [7:0]  in_sup = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_mag_idx = '0;
    logic [3:0]  wr_sup_idx = '0;
    logic [31:0] wr_data = '0;
    logic        out_valid;
    logic [15:0] out_i, out_q;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   rst_next = 1'b1;
    int   tab_i [MPTS*SPTS];
    int   tab_q [MPTS*SPTS];
    exp_t eq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpd_twoaxis_predist u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_mag(in_mag), .in_sup(in_sup), .wr_en(wr_en), .wr_mag_idx(wr_mag_idx),
        .wr_sup_idx(wr_sup_idx), .wr_data(wr_data),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int sat16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic void model(input int xi, xq, mag, sup, output int yi, yq);
        int mi, fm, mh, si, fs, sh;
        longint g00, g10, g01, g11, a0, a1, gi, gq, p;
        mi = mag >> 6; fm = mag & 63; mh = (mi == MPTS-1) ? mi : mi + 1;
        si = sup >> 4; fs = sup & 15; sh = (si == SPTS-1) ? si : si + 1;
        g00 = tab_i[si*MPTS+mi]; g10 = tab_i[si*MPTS+mh];
        g01 = tab_i[sh*MPTS+mi]; g11 = tab_i[sh*MPTS+mh];
        a0 = g00*(64-fm) + g10*fm; a1 = g01*(64-fm) + g11*fm;
        gi = (a0*(16-fs) + a1*fs + 512) >>> 10;
        g00 = tab_q[si*MPTS+mi]; g10 = tab_q[si*MPTS+mh];
        g01 = tab_q[sh*MPTS+mi]; g11 = tab_q[sh*MPTS+mh];
        a0 = g00*(64-fm) + g10*fm; a1 = g01*(64-fm) + g11*fm;
        gq = (a0*(16-fs) + a1*fs + 512) >>> 10;
        p  = longint'(xi)*gi - longint'(xq)*gq;
        yi = sat16((p + 8192) >>> 14);
        p  = longint'(xi)*gq + longint'(xq)*gi;
        yq = sat16((p + 8192) >>> 14);
    endfunction

    task automatic compare();
        exp_t e;
        int ai, aq;
        if (eq.size() < LAT) return;
        e = eq.pop_front();
        n_chk++;
        ai = int'($signed(out_i));
        aq = int'($signed(out_q));
        if (out_valid !== e.v) begin
            n_bad++;
            $display("FAIL %s valid actual %0b expected %0b", e.tag, out_valid, e.v);
        end else if (e.v && (ai != e.i || aq != e.q)) begin
            n_bad++;
            $display("FAIL %s data actual (%0d,%0d) expected (%0d,%0d)", e.tag, ai, aq, e.i, e.q);
        end
    endtask

    task automatic cyc(input bit v, input int xi, input int xq, input int mag, input int sup,
                       input string tg, input bit we = 0, input int wm = 0, input int ws = 0,
                       input int wi = 0, input int wq = 0);
        exp_t e;
        @(negedge clk);
        compare();
        if (rst_next && !rst) begin
            foreach (eq[k]) eq[k].v = 1'b0;
        end
        rst        = rst_next;
        in_valid   = v;
        in_i       = 16'(xi);
        in_q       = 16'(xq);
        in_mag     = 12'(mag);
        in_sup     = 8'(sup);
        wr_en      = we;
        wr_mag_idx = 6'(wm);
        wr_sup_idx = 4'(ws);
        wr_data    = {16'(wi), 16'(wq)};
        e.v   = v && !rst_next;
        e.tag = tg;
        e.i   = 0;
        e.q   = 0;
        if (e.v) model(xi, xq, mag, sup, e.i, e.q);
        eq.push_back(e);
        if (we) begin
            tab_i[ws*MPTS+wm] = wi;
            tab_q[ws*MPTS+wm] = wq;
        end
    endtask

    task automatic idle(input int n, input string tg);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, tg);
    endtask

    task automatic wcell(input int wm, input int ws, input int wi, input int wq);
        cyc(0, 0, 0, 0, 0, "R7", 1, wm, ws, wi, wq);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R5 watchdog actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // reset
        idle(4, "R8");
        rst_next = 1'b0;
        cyc(0, 0, 0, 0, 0, "R8");
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R8 reset state actual %0b expected 0", out_valid);
        end

        // load every cell; valid stays low throughout (R5)
        for (int s = 0; s < SPTS; s++)
            for (int m = 0; m < MPTS; m++)
                cyc(0, 0, 0, 0, 0, "R5", 1, m, s,
                    8000 + (m*137 + s*389) % 16000, ((m*71 + s*29) % 8192) - 4096);
        idle(LAT, "R5");

        // R1: index and fraction split
        cyc(1, 12000, -7000, (20 << 6) | 37, (7 << 4) | 9, "R1");
        cyc(1, -20000, 3000, (45 << 6) | 1, (2 << 4) | 15, "R1");
        // R3: interior blends at several fractions
        cyc(1, 9000, 9000, (3 << 6) | 32, (11 << 4) | 8, "R3");
        cyc(1, -1, 1, (60 << 6) | 63, (0 << 4) | 1, "R3");
        // R2: last grid point on each axis and both
        cyc(1, 15000, -15000, 12'hFFF, 8'h35, "R2");
        cyc(1, -15000, 4000, 12'h2A7, 8'hFF, "R2");
        cyc(1, 30000, 30000, 12'hFC5, 8'hF7, "R2");

        // R4: unity and saturation regions
        for (int s = 3; s <= 4; s++)
            for (int m = 10; m <= 11; m++) wcell(m, s, 16384, 0);
        for (int s = 0; s <= 1; s++)
            for (int m = 0; m <= 1; m++) wcell(m, s, 32767, 0);
        cyc(1, 12345, -23456, (10 << 6) | 17, (3 << 4) | 5, "R4");
        cyc(1, -32768, 32767, (10 << 6), (3 << 4), "R4");
        cyc(1, 32767, -32768, 0, 0, "R4");
        cyc(1, -32768, -32768, 0, 0, "R4");
        cyc(1, 1, -1, 0, 0, "R4");

        // R7: write and read of one cell in the same cycle, then the next
        cyc(1, 10000, 5000, (5 << 6), (5 << 4), "R7", 1, 5, 5, -12000, 6000);
        cyc(1, 10000, 5000, (5 << 6), (5 << 4), "R7");
        idle(2, "R5");

        // R8: reset while samples are in flight; table must survive
        cyc(1, 2000, 3000, 12'h444, 8'h44, "R8");
        cyc(1, 2000, 3000, 12'h555, 8'h55, "R8");
        rst_next = 1'b1;
        idle(2, "R8");
        rst_next = 1'b0;
        cyc(1, 10000, 5000, (5 << 6), (5 << 4), "R8");
        cyc(1, -9000, 7000, 12'h9AB, 8'hC3, "R8");

        // R6: random stream with gaps and occasional writes
        for (int k = 0; k < 3000; k++) begin
            bit w;
            w = ($urandom_range(0, 19) == 0);
            cyc($urandom_range(0, 3) != 0,
                int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                int'($urandom_range(0, 4095)), int'($urandom_range(0, 255)), "R6",
                w, int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768);
        end
        idle(LAT + 2, "R5");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule